// File: doc/BRIEF.md
# Power-On Strap Capture with Shared Clock Pins

This block reads board configuration from four pins that also carry clocks. While power-on reset is held, the pins are inputs. A pull resistor on each pin sets its level: pulled to supply reads as 1, pulled to ground reads as 0. The block passes these levels through an optional synchronizer clocked by the reference clock.

On the first reference clock edge after reset is released, the block stores the synchronized levels in a 4-bit configuration word. The word then sets the operating mode until the next power-on reset. One reference clock after that capture, the block turns on the output enables. From then on, each pin carries the clock assigned to it.

The output enables stay off for the whole of reset and through the capture edge. This keeps an output driver from fighting the strap resistor while its level is being read.

Top module: `pin_strap_capture`

## Requirements
- R1: While `por_n` is low, every bit of `pad_oe`, `pad_out` and `strap_cfg` is 0. A fall of `por_n` clears `pad_oe` and `strap_cfg` at once, without waiting for a clock edge.
- R2: On the first rising edge of `clk_ref` with `por_n` high, `strap_cfg[i]` takes the synchronized level of `pad_in[i]` (1 = pin high). Bits 2..0 are the three frequency-select bits and bit 3 is the bus-mode select bit.
- R3: `pad_oe` is still all 0 after the capture edge and becomes all 1 on the next rising edge of `clk_ref`.
- R4: After capture, `strap_cfg` does not change, whatever `pad_in` does, until `por_n` falls again.
- R5: Each `pad_out[i]` equals `clk_src[i]` while `pad_oe[i]` is 1 and is 0 otherwise.
- R6: A new reset after normal operation withdraws the enables, and the next release captures the straps again with fresh levels.
- R7: All 16 strap combinations are captured exactly.
- R8: With `SYNC_STAGES` = S > 0, the captured value is the pin level sampled S clock edges before the capture edge. A change in the last S cycles before the capture edge does not reach the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| pad_in | input | NPIN | Level seen at each shared pin |
| pad_out | output | NPIN | Value driven onto each shared pin |
| pad_oe | output | NPIN | Output enable per shared pin, 1 = drive |
| clk_src | input | NPIN | Clocks to forward onto the pins after start-up |
| strap_cfg | output | NPIN | Latched configuration word |

## Verification
The bench goes after the turnaround window. A design that enabled its drivers at the capture edge, or during reset, would drive the pin while the strap is being read. The bench would see `pad_oe` high one cycle early.

Pin levels are changed inside the synchronizer window just before release. A design that bypassed or shortened the synchronizer would capture the new value instead of the old one. After capture the pins are toggled. A design that kept sampling would let the word follow them.

A reset in mid-operation is applied. A design with a synchronous clear would keep driving during reset. A design that failed to re-arm would keep the stale word.

// File: rtl/pin_strap_capture.sv
module pin_strap_capture #(
  parameter int NPIN        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_ref,
  input  logic            por_n,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  input  logic [NPIN-1:0] clk_src,
  output logic [NPIN-1:0] strap_cfg
);

  logic [NPIN-1:0] strap_s;
  logic            captured;
  logic            drive_en;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign strap_s = pad_in;
    end else begin : g_sync
      logic [NPIN-1:0] stg [SYNC_STAGES];
      always_ff @(posedge clk_ref) begin
        stg[0] <= pad_in;
        for (int k = 1; k < SYNC_STAGES; k++) stg[k] <= stg[k-1];
      end
      assign strap_s = stg[SYNC_STAGES-1];
    end
  endgenerate

  // capture once per reset, enable drivers one clock later
  always_ff @(posedge clk_ref or negedge por_n) begin
    if (!por_n) begin
      captured  <= 1'b0;
      strap_cfg <= '0;
      drive_en  <= 1'b0;
    end else begin
      if (!captured) begin
        strap_cfg <= strap_s;
        captured  <= 1'b1;
      end
      drive_en <= captured;
    end
  end

  assign pad_oe  = {NPIN{drive_en}};
  assign pad_out = clk_src & pad_oe;

endmodule

// File: rtl/pin_strap_capture_chk.sv
module pin_strap_capture_chk #(
  parameter int NPIN = 4
) (
  input logic            clk_ref,
  input logic            por_n,
  input logic [NPIN-1:0] pad_in,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] strap_cfg
);

  logic [1:0] rel_cnt;

  always_ff @(posedge clk_ref or negedge por_n) begin
    if (!por_n) rel_cnt <= 2'd0;
    else if (rel_cnt != 2'd3) rel_cnt <= rel_cnt + 2'd1;
  end

  always_ff @(posedge clk_ref) begin
    if (!por_n) begin
      a_r1_quiet_in_reset: assert (pad_oe == '0 && strap_cfg == '0 && pad_out == '0)
        else $error("R1: outputs active during reset");
    end
  end

  a_r3_off_at_capture: assert property (@(posedge clk_ref) disable iff (!por_n)
    (rel_cnt == 2'd1) |-> (pad_oe == '0));

  a_r3_on_after_capture: assert property (@(posedge clk_ref) disable iff (!por_n)
    (rel_cnt >= 2'd2) |-> (pad_oe == {NPIN{1'b1}}));

  a_r4_cfg_frozen: assert property (@(posedge clk_ref) disable iff (!por_n)
    (rel_cnt >= 2'd1) |=> $stable(strap_cfg));

  a_r5_no_drive_when_off: assert property (@(posedge clk_ref) disable iff (!por_n)
    ((pad_out & ~pad_oe) == '0));

  logic unused_ok;
  assign unused_ok = ^pad_in;

endmodule

bind pin_strap_capture pin_strap_capture_chk #(.NPIN(NPIN)) u_chk (
  .clk_ref   (clk_ref),
  .por_n     (por_n),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .strap_cfg (strap_cfg)
);

// File: tb/test_pin_strap_capture.sv
`timescale 1ns/1ps
module test_pin_strap_capture;
  localparam int NPIN = 4;
  localparam int SYNC = 2;

  logic            clk = 1'b0;
  logic            por_n = 1'b0;
  logic [NPIN-1:0] pad_in = '0;
  logic [NPIN-1:0] clk_src = '0;
  logic [NPIN-1:0] pad_out, pad_oe, strap_cfg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_strap_capture #(.NPIN(NPIN), .SYNC_STAGES(SYNC)) i_pin_strap_capture (
    .clk_ref(clk), .por_n(por_n), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .clk_src(clk_src), .strap_cfg(strap_cfg));

  // behavioural reference model
  logic [NPIN-1:0] hist[$];
  bit              m_cap = 0;
  bit              m_oe  = 0;
  logic [NPIN-1:0] m_cfg = '0;

  always @(negedge por_n) begin
    m_cap = 0; m_oe = 0; m_cfg = '0;
  end

  always @(posedge clk) begin
    if (por_n) begin
      bit was;
      logic [NPIN-1:0] s;
      was = m_cap;
      if (SYNC == 0) s = pad_in;
      else s = hist[hist.size()-SYNC];
      if (!m_cap) begin m_cfg = s; m_cap = 1; end
      m_oe = was;
    end
    hist.push_back(pad_in);
    if (hist.size() > 8) void'(hist.pop_front());
  end

  task automatic chk(input string req, input logic [NPIN-1:0] act, input logic [NPIN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic [NPIN-1:0] e_oe;
      e_oe = m_oe ? '1 : '0;
      if (!por_n) begin
        chk("R1 oe", pad_oe, '0);
        chk("R1 cfg", strap_cfg, '0);
      end else begin
        chk("R3 oe", pad_oe, e_oe);
        chk("R2 cfg", strap_cfg, m_cfg);
      end
      chk("R5 out", pad_out, clk_src & e_oe);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin : src_gen
    int c = 0;
    forever begin
      @(posedge clk); #1;
      c++;
      clk_src = NPIN'(c) ^ NPIN'(c >> 3);
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(4);
    chk("R1 oe at start", pad_oe, '0);
    chk("R1 cfg at start", strap_cfg, '0);

    for (int c = 0; c < 16; c++) begin
      por_n = 1'b0;
      #1;
      chk("R6 oe drops at once", pad_oe, '0);
      pad_in = NPIN'(c);
      step(5);
      por_n = 1'b1;
      step(1);
      chk("R3 oe low at capture", pad_oe, '0);
      chk("R7 combo captured", strap_cfg, NPIN'(c));
      step(1);
      chk("R3 oe high next clock", pad_oe, '1);
      pad_in = ~NPIN'(c);
      step(3);
      pad_in = NPIN'(c * 5);
      step(2);
      chk("R4 cfg unchanged by pins", strap_cfg, NPIN'(c));
    end

    // late change inside the synchronizer window
    por_n = 1'b0;
    pad_in = 4'hA;
    step(5);
    pad_in = 4'h5;
    step(1);
    por_n = 1'b1;
    step(1);
    chk("R8 late change not captured", strap_cfg, 4'hA);
    step(1);
    chk("R3 oe after late case", pad_oe, '1);

    // change just outside the window is captured
    por_n = 1'b0;
    pad_in = 4'h3;
    step(5);
    pad_in = 4'hC;
    step(2);
    por_n = 1'b1;
    step(1);
    chk("R8 early change captured", strap_cfg, 4'hC);

    // mid-operation reset re-arms capture
    step(6);
    por_n = 1'b0;
    #1;
    chk("R6 oe cleared", pad_oe, '0);
    chk("R6 cfg cleared", strap_cfg, '0);
    pad_in = 4'h9;
    step(4);
    por_n = 1'b1;
    step(2);
    chk("R6 recapture", strap_cfg, 4'h9);
    chk("R6 oe back on", pad_oe, '1);
    step(3);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule